// File: doc/BRIEF.md
# Two-Channel DMA Bus Arbiter

This block decides who owns a shared bus: the processor or one of two DMA channels. Each channel presents an enable and a request line. The request is sampled once per clock period and stored in a single pending bit per channel. Requests that repeat before service collapse into that one bit. When the processor owns the bus and a pending, enabled request exists, the lowest-numbered channel wins and receives the bus. Its pending bit is cleared at that same edge.

A granted channel keeps the bus for exactly one transfer, which the datapath ends with a done strobe. The bus then returns to the processor. No further DMA grant is issued until the processor reports one completed bus access. Address generation, counters and the data movement itself belong elsewhere. The arbiter only produces the grant lines.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it falls, `grant_cpu` is 1, `grant_ch` is 0 and no request is pending.
- R2: A request seen high at a rising edge while its enable is high makes the channel pending. If the processor owns the bus with no access owed, the channel's grant appears after the following rising edge, so two edges after the request. Bit i of `grant_ch` is channel i.
- R3: A request seen while the channel's enable is low sets nothing, and no grant for that channel follows.
- R4: A pending request is discarded at any edge where its channel's enable is low. Enabling the channel again does not bring it back.
- R5: When both channels are pending and eligible at the same decision edge, channel 0 is granted first.
- R6: A channel grant holds unchanged until an edge with `xfer_done` high. After that edge `grant_cpu` is 1.
- R7: After a DMA transfer, no channel is granted until an edge with `cpu_access_done` high while `grant_cpu` is 1. A pending channel is granted at that same edge.
- R8: Any number of requests on one channel before its service yield exactly one transfer.
- R9: A request that arrives on a channel in the cycle its grant is taken, or later, leaves the channel pending again, and it is served in a later slot.
- R10: Exactly one of `grant_cpu` and the bits of `grant_ch` is 1 in every cycle.
- R11: With both channels pending, channel 1 is granted only after the channel 0 transfer, a return of the bus to the processor, and one processor access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one request sampling window |
| rst | input | 1 | Synchronous reset, active high |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_req | input | NUM_CH | Per-channel transfer request |
| cpu_access_done | input | 1 | Processor finished one bus access this cycle |
| xfer_done | input | 1 | Datapath finished the granted transfer this cycle |
| grant_cpu | output | 1 | Processor owns the bus |
| grant_ch | output | NUM_CH | One-hot channel grant |

## Verification
A request reaches the pending bit at the first rising edge. From an idle processor slot, the grant is then visible after the second edge. `xfer_done` and `cpu_access_done` take effect at the single edge that samples them. The bench therefore drives every input on a falling edge and holds it across exactly one rising edge. It compares the grant lines at the next falling edge, or two falling edges after a request. Waits that must not produce a grant are checked on every falling edge of the window, and each of those checks also confirms that exactly one grant line is high.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    // Bus owner state
    typedef enum logic [1:0] {
        BUS_CPU_FREE = 2'd0,  // processor owns bus, DMA may take it
        BUS_CPU_OWED = 2'd1,  // processor owns bus, one access owed first
        BUS_DMA      = 2'd2   // a channel owns bus for one transfer
    } bus_state_e;

    // Width of a channel index, never less than one bit
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dma_req_flag.sv
module dma_req_flag (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic req,
    input  logic take,
    output logic pending
);
    logic pending_q;

    // take clears, a request in the same cycle sets again, enable low discards
    always_ff @(posedge clk) begin
        if (rst)
            pending_q <= 1'b0;
        else if (!en)
            pending_q <= 1'b0;
        else
            pending_q <= (pending_q & ~take) | req;
    end

    assign pending = pending_q;
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1
) (
    input  logic [NUM_CH-1:0] elig,
    output logic              any_elig,
    output logic [CH_W-1:0]   win_idx
);
    // lowest index wins: scan high to low, last hit stays
    always_comb begin
        any_elig = 1'b0;
        win_idx  = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (elig[i]) begin
                any_elig = 1'b1;
                win_idx  = CH_W'(i);
            end
        end
    end
endmodule

// File: rtl/dma_bus_owner.sv
module dma_bus_owner
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              any_elig,
    input  logic [CH_W-1:0]   win_idx,
    input  logic              cpu_access_done,
    input  logic              xfer_done,
    output logic [NUM_CH-1:0] take,
    output logic              grant_cpu,
    output logic [NUM_CH-1:0] grant_ch
);
    bus_state_e      state_q, state_n;
    logic [CH_W-1:0] idx_q;
    logic            grant_now;

    always_comb begin
        grant_now = 1'b0;
        state_n   = state_q;
        unique case (state_q)
            BUS_CPU_FREE: begin
                if (any_elig) begin
                    grant_now = 1'b1;
                    state_n   = BUS_DMA;
                end
            end
            BUS_CPU_OWED: begin
                if (cpu_access_done) begin
                    grant_now = any_elig;
                    state_n   = any_elig ? BUS_DMA : BUS_CPU_FREE;
                end
            end
            BUS_DMA: begin
                if (xfer_done)
                    state_n = BUS_CPU_OWED;
            end
            default: state_n = BUS_CPU_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BUS_CPU_FREE;
            idx_q   <= '0;
        end else begin
            state_q <= state_n;
            if (grant_now)
                idx_q <= win_idx;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            take[i]     = grant_now && (win_idx == CH_W'(i));
            grant_ch[i] = (state_q == BUS_DMA) && (idx_q == CH_W'(i));
        end
    end

    assign grant_cpu = (state_q != BUS_DMA);
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] ch_req,
    input  logic              cpu_access_done,
    input  logic              xfer_done,
    output logic              grant_cpu,
    output logic [NUM_CH-1:0] grant_ch
);
    localparam int CH_W = dma_arb_pkg::idx_width(NUM_CH);

    logic [NUM_CH-1:0] pending;
    logic [NUM_CH-1:0] elig;
    logic [NUM_CH-1:0] take;
    logic              any_elig;
    logic [CH_W-1:0]   win_idx;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_flag
        dma_req_flag u_flag (
            .clk     (clk),
            .rst     (rst),
            .en      (ch_en[g]),
            .req     (ch_req[g]),
            .take    (take[g]),
            .pending (pending[g])
        );
    end

    assign elig = pending & ch_en;

    dma_prio_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
        .elig     (elig),
        .any_elig (any_elig),
        .win_idx  (win_idx)
    );

    dma_bus_owner #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_owner (
        .clk             (clk),
        .rst             (rst),
        .any_elig        (any_elig),
        .win_idx         (win_idx),
        .cpu_access_done (cpu_access_done),
        .xfer_done       (xfer_done),
        .take            (take),
        .grant_cpu       (grant_cpu),
        .grant_ch        (grant_ch)
    );
endmodule

// File: rtl/dma_bus_arbiter_checker.sv
module dma_bus_arbiter_checker #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] ch_en,
    input logic              cpu_access_done,
    input logic              xfer_done,
    input logic              grant_cpu,
    input logic [NUM_CH-1:0] grant_ch,
    input logic [NUM_CH-1:0] pending
);
    // processor access owed after each DMA transfer
    logic owed;
    always_ff @(posedge clk) begin
        if (rst)
            owed <= 1'b0;
        else if ((|grant_ch) && xfer_done)
            owed <= 1'b1;
        else if (grant_cpu && cpu_access_done)
            owed <= 1'b0;
    end

    a_r1_reset_grant: assert property (@(posedge clk)
        rst |=> (grant_cpu && (grant_ch == '0) && (pending == '0)));

    a_r10_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot({grant_cpu, grant_ch}));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        ((|grant_ch) && !xfer_done) |=> (grant_ch == $past(grant_ch)));

    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        ((|grant_ch) && xfer_done) |=> grant_cpu);

    a_r7_cpu_first: assert property (@(posedge clk) disable iff (rst)
        (grant_cpu && owed && !cpu_access_done) |=> grant_cpu);

    a_r3_disabled_no_grant: assert property (@(posedge clk) disable iff (rst)
        (grant_cpu && !ch_en[0]) |=> !grant_ch[0]);

    if (NUM_CH >= 2) begin : g_prio
        a_r5_low_wins: assert property (@(posedge clk) disable iff (rst)
            (grant_cpu && pending[0] && ch_en[0]) |=> (grant_ch[NUM_CH-1:1] == '0));
    end
endmodule

bind dma_bus_arbiter dma_bus_arbiter_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .ch_en           (ch_en),
    .cpu_access_done (cpu_access_done),
    .xfer_done       (xfer_done),
    .grant_cpu       (grant_cpu),
    .grant_ch        (grant_ch),
    .pending         (pending)
);

// File: tb/dma_bus_arbiter_test.sv
module dma_bus_arbiter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ch_en = 2'b11;
    logic [1:0] ch_req = 2'b00;
    logic       cpu_access_done = 1'b0;
    logic       xfer_done = 1'b0;
    logic       grant_cpu;
    logic [1:0] grant_ch;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    dma_bus_arbiter #(.NUM_CH(2)) uut (
        .clk             (clk),
        .rst             (rst),
        .ch_en           (ch_en),
        .ch_req          (ch_req),
        .cpu_access_done (cpu_access_done),
        .xfer_done       (xfer_done),
        .grant_cpu       (grant_cpu),
        .grant_ch        (grant_ch)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_bus(input logic e_cpu, input logic [1:0] e_ch, input string tag);
        n_checks++;
        if (grant_cpu !== e_cpu || grant_ch !== e_ch) begin
            n_fail++;
            $display("FAIL %s: grant_cpu=%0b grant_ch=%b, expected grant_cpu=%0b grant_ch=%b",
                     tag, grant_cpu, grant_ch, e_cpu, e_ch);
        end
        n_checks++;
        if ($countones({grant_cpu, grant_ch}) != 1) begin
            n_fail++;
            $display("FAIL R10 one grant: grant_cpu=%0b grant_ch=%b, expected exactly one high",
                     grant_cpu, grant_ch);
        end
    endtask

    task automatic do_reset();
        tick();
        rst = 1'b1; ch_en = 2'b11; ch_req = 2'b00;
        cpu_access_done = 1'b0; xfer_done = 1'b0;
        tick();
        tick();
        expect_bus(1'b1, 2'b00, "R1 during reset");
        rst = 1'b0;
    endtask

    task automatic pulse_req(input logic [1:0] v);
        ch_req = v; tick(); ch_req = 2'b00;
    endtask

    task automatic pulse_xfer();
        xfer_done = 1'b1; tick(); xfer_done = 1'b0;
    endtask

    task automatic pulse_access();
        cpu_access_done = 1'b1; tick(); cpu_access_done = 1'b0;
    endtask

    task automatic t_single();
        do_reset();
        tick();
        expect_bus(1'b1, 2'b00, "R1 after reset");
        pulse_req(2'b01);
        expect_bus(1'b1, 2'b00, "R2 one edge after request");
        tick();
        expect_bus(1'b0, 2'b01, "R2 grant two edges after request");
        for (int k = 0; k < 3; k++) begin
            tick();
            expect_bus(1'b0, 2'b01, "R6 grant holds");
        end
        pulse_xfer();
        expect_bus(1'b1, 2'b00, "R6 release after transfer");
    endtask

    task automatic t_disabled();
        do_reset();
        ch_en = 2'b10;
        pulse_req(2'b01);
        expect_bus(1'b1, 2'b00, "R3 disabled request");
        for (int k = 0; k < 3; k++) begin
            tick();
            expect_bus(1'b1, 2'b00, "R3 disabled request");
        end
        ch_en = 2'b11;
        for (int k = 0; k < 3; k++) begin
            tick();
            expect_bus(1'b1, 2'b00, "R3 nothing latched");
        end
    endtask

    task automatic t_enable_drop();
        do_reset();
        pulse_req(2'b01);
        ch_en = 2'b10;
        tick();
        expect_bus(1'b1, 2'b00, "R4 enable low discards");
        ch_en = 2'b11;
        for (int k = 0; k < 4; k++) begin
            tick();
            expect_bus(1'b1, 2'b00, "R4 not restored");
        end
    endtask

    task automatic t_both();
        do_reset();
        pulse_req(2'b11);
        tick();
        expect_bus(1'b0, 2'b01, "R5 channel 0 first");
        pulse_xfer();
        expect_bus(1'b1, 2'b00, "R11 back to processor");
        for (int k = 0; k < 3; k++) begin
            tick();
            expect_bus(1'b1, 2'b00, "R7 waits for processor access");
        end
        pulse_access();
        expect_bus(1'b0, 2'b10, "R11 channel 1 after access");
        pulse_xfer();
        expect_bus(1'b1, 2'b00, "R6 release channel 1");
        pulse_access();
        for (int k = 0; k < 3; k++) begin
            tick();
            expect_bus(1'b1, 2'b00, "R8 nothing left pending");
        end
    endtask

    task automatic t_merge();
        do_reset();
        pulse_req(2'b01);
        tick();
        expect_bus(1'b0, 2'b01, "R2 first grant");
        pulse_xfer();
        for (int k = 0; k < 3; k++) begin
            pulse_req(2'b01);
            tick();
            expect_bus(1'b1, 2'b00, "R7 held off while access owed");
        end
        pulse_access();
        expect_bus(1'b0, 2'b01, "R7 grant at access edge");
        pulse_xfer();
        pulse_access();
        for (int k = 0; k < 4; k++) begin
            tick();
            expect_bus(1'b1, 2'b00, "R8 repeats merged");
        end
    endtask

    task automatic t_regrant();
        do_reset();
        ch_req = 2'b01;
        tick();
        tick();
        ch_req = 2'b00;
        expect_bus(1'b0, 2'b01, "R9 first grant");
        pulse_xfer();
        expect_bus(1'b1, 2'b00, "R6 release");
        pulse_access();
        expect_bus(1'b0, 2'b01, "R9 request at grant edge served again");
        pulse_xfer();
        ch_req = 2'b01;
        pulse_xfer();
        ch_req = 2'b00;
        pulse_access();
        expect_bus(1'b0, 2'b01, "R9 request after grant served");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_single();
        t_disabled();
        t_enable_drop();
        t_both();
        t_merge();
        t_regrant();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule